// File: doc/BRIEF.md
# Majority-Logic Full-Adder Sequencer

This block runs a one-bit full addition inside a resistive memory array. The array can only do two things besides plain storage. It can sense the three-input majority of three rows in one column, and it can return the inverted value of any sensed result. The sequencer turns the addition into a network of those two operations. It issues a fixed six-step program of inverted reads, majority senses, inverted majority senses and writes to the array's operation controller. The values it senses are written back into scratch cells, and the final sum and carry are returned on its own outputs.

The caller places the operands before pulsing `start`. In the primary column (`base_col`), A, B and Cin go at rows base, base+1 and base+2. In the secondary column (`base_col + SA_SHARE`), A and B go at rows base and base+1, and a copy of Cin goes at base+3. Rows base+2, base+4 and base+5 of the secondary column are used as scratch. The two columns lie in different sense-amplifier groups, because `SA_SHARE` bitlines share one amplifier. Two gates can therefore be evaluated in the same memory cycle, one per command lane. Lane 0 always addresses the primary column and lane 1 the secondary column.

The network used is carry = MAJ(A,B,Cin) and sum = MAJ(NOT carry, Cin, MAJ(A,B,NOT Cin)). One clock is one memory cycle. The controller returns the sensed bit of each lane on `sense_dat` combinationally, in the same cycle as the command.

Top module: `mfa_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, `cmd_vld`, `busy`, `done`, `sum` and `carry` are all 0.
- R2: A `start` sampled while idle latches `base_row` and `base_col`. The first command appears in the next cycle. Commands occupy exactly six consecutive cycles, during which `busy` is 1. No command is issued while `busy` is 0.
- R3: Op codes are 0 none, 1 inverted single-row read, 2 majority, 3 inverted majority, 4 write. A lane with no command drives op, row, column and write data as 0. The program, as (cycle: lane op row-offset), is: 1: L0 op1 +2. 2: L1 op4 +2. 3: L0 op3 +0 and L1 op2 +0. 4: L1 op4 +4. 5: L1 op4 +5. 6: L0 op2 +0 and L1 op2 +3.
- R4: The row of a command is the latched base row plus its offset, modulo 2^ROW_W. Lane 0 uses the latched base column. Lane 1 uses the base column plus SA_SHARE, modulo 2^COL_W.
- R5: Two commands share a cycle only in cycles 3 and 6. One addition issues five sense operations and three writes.
- R6: Write data is taken from the lane whose result it stores. Cycle 2 writes the lane-0 bit sensed in cycle 1. Cycle 4 writes the lane-0 bit sensed in cycle 3. Cycle 5 writes the lane-1 bit sensed in cycle 3.
- R7: `carry` takes the lane-0 bit and `sum` the lane-1 bit sensed in cycle 6. With a correctly behaving array, they equal the arithmetic carry and sum of A+B+Cin.
- R8: `done` is a one-cycle pulse in the cycle after cycle 6. `sum` and `carry` stay unchanged while idle until the next accepted start.
- R9: A `start` sampled while busy is ignored. It neither restarts the program, nor changes the latched base, nor starts a new addition after the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one addition |
| base_row | input | ROW_W | First operand row |
| base_col | input | COL_W | Primary operand column |
| cmd_vld | output | 2 | Per-lane command valid |
| cmd_op | output | 6 | Per-lane op code, 3 bits per lane |
| cmd_row | output | 2*ROW_W | Per-lane row address |
| cmd_col | output | 2*COL_W | Per-lane column address |
| cmd_wdat | output | 2 | Per-lane write data |
| sense_dat | input | 2 | Per-lane sensed bit from the controller |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 1 | Sum bit of the last addition |
| carry | output | 1 | Carry bit of the last addition |

## Verification
The bench builds the block with ROW_W=4, COL_W=5 and SA_SHARE=8. With only 16 rows and 32 columns, a base near the top of the row space makes the six-row footprint wrap. A base column near the end puts the secondary column past the edge, so it wraps to a low column. This tests the modulo addressing of R4 against a small array model that the bench keeps itself. All eight operand combinations are tested, along with random bases and operands. A start is injected in mid-program, with a different base, to expose any restart or relatch.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  localparam int OP_W   = 3;
  localparam int LANES  = 2;
  localparam int NSTEP  = 6;
  localparam int STEP_W = $clog2(NSTEP);
  localparam int NSLOT  = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_RDN  = 3'd1,
    OP_MAJ  = 3'd2,
    OP_MAJN = 3'd3,
    OP_WR   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SL_NONE = 3'd0,
    SL_NCIN = 3'd1,
    SL_NCAR = 3'd2,
    SL_MID  = 3'd3,
    SL_SUM  = 3'd4,
    SL_CAR  = 3'd5
  } slot_e;

  typedef struct packed {
    logic  en;
    op_e   op;
    logic [2:0] roff;
    logic  grp;
    slot_e wsrc;
  } iss_t;

  localparam iss_t ISS_IDLE = '{en: 1'b0, op: OP_NOP, roff: 3'd0, grp: 1'b0, wsrc: SL_NONE};
endpackage

// File: rtl/mfa_prog.sv
module mfa_prog
  import mfa_pkg::*;
(
  input  logic [STEP_W-1:0]          iss_step,
  input  logic [STEP_W-1:0]          cap_step,
  output iss_t  [LANES-1:0]          iss,
  output slot_e [LANES-1:0]          cap
);

  function automatic iss_t mk(op_e op, int unsigned roff, logic grp, slot_e src);
    iss_t u;
    u.en   = 1'b1;
    u.op   = op;
    u.roff = 3'(roff);
    u.grp  = grp;
    u.wsrc = src;
    return u;
  endfunction

  // issue side: what each lane sends in a given step
  always_comb begin
    for (int l = 0; l < LANES; l++) iss[l] = ISS_IDLE;
    case (iss_step)
      3'd0: iss[0] = mk(OP_RDN,  2, 1'b0, SL_NONE);
      3'd1: iss[1] = mk(OP_WR,   2, 1'b1, SL_NCIN);
      3'd2: begin
        iss[0] = mk(OP_MAJN, 0, 1'b0, SL_NONE);
        iss[1] = mk(OP_MAJ,  0, 1'b1, SL_NONE);
      end
      3'd3: iss[1] = mk(OP_WR,   4, 1'b1, SL_NCAR);
      3'd4: iss[1] = mk(OP_WR,   5, 1'b1, SL_MID);
      3'd5: begin
        iss[0] = mk(OP_MAJ,  0, 1'b0, SL_NONE);
        iss[1] = mk(OP_MAJ,  3, 1'b1, SL_NONE);
      end
      default: ;
    endcase
  end

  // capture side: where each lane's sensed bit is stored in a given step
  always_comb begin
    for (int l = 0; l < LANES; l++) cap[l] = SL_NONE;
    case (cap_step)
      3'd0: cap[0] = SL_NCIN;
      3'd2: begin
        cap[0] = SL_NCAR;
        cap[1] = SL_MID;
      end
      3'd5: begin
        cap[0] = SL_CAR;
        cap[1] = SL_SUM;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mfa_scratch.sv
module mfa_scratch
  import mfa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  slot_e [LANES-1:0]     cap,
  input  logic  [LANES-1:0]     sense,
  output logic  [NSLOT-1:0]     slot_nxt,
  output logic                  sum_q,
  output logic                  carry_q
);

  logic [NSLOT-1:0] slot_q;

  // next-state view is forwarded to the lanes so a write may follow its capture directly
  always_comb begin
    slot_nxt = slot_q;
    if (cap_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (cap[l] != SL_NONE) slot_nxt[cap[l]] = sense[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_nxt;
  end

  assign sum_q   = slot_q[SL_SUM];
  assign carry_q = slot_q[SL_CAR];

endmodule

// File: rtl/mfa_lane.sv
module mfa_lane
  import mfa_pkg::*;
#(
  parameter int ROW_W   = 6,
  parameter int COL_W   = 7,
  parameter int GRP_OFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  iss_t              uop,
  input  logic [ROW_W-1:0]  base_row,
  input  logic [COL_W-1:0]  base_col,
  input  logic [NSLOT-1:0]  fwd,
  output logic              vld,
  output logic [OP_W-1:0]   op,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic              wdat
);

  localparam logic [COL_W-1:0] COL_OFS = COL_W'(GRP_OFS);

  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             wd_d;

  always_comb begin
    row_d = base_row + ROW_W'(uop.roff);
    col_d = base_col + (uop.grp ? COL_OFS : '0);
    wd_d  = (uop.wsrc != SL_NONE) ? fwd[uop.wsrc] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !uop.en) begin
      vld  <= 1'b0;
      op   <= OP_NOP;
      row  <= '0;
      col  <= '0;
      wdat <= 1'b0;
    end else begin
      vld  <= 1'b1;
      op   <= uop.op;
      row  <= row_d;
      col  <= col_d;
      wdat <= wd_d;
    end
  end

endmodule

// File: rtl/mfa_seq.sv
module mfa_seq
  import mfa_pkg::*;
#(
  parameter int ROW_W    = 6,
  parameter int COL_W    = 7,
  parameter int SA_SHARE = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ROW_W-1:0]        base_row,
  input  logic [COL_W-1:0]        base_col,
  output logic [LANES-1:0]        cmd_vld,
  output logic [LANES*OP_W-1:0]   cmd_op,
  output logic [LANES*ROW_W-1:0]  cmd_row,
  output logic [LANES*COL_W-1:0]  cmd_col,
  output logic [LANES-1:0]        cmd_wdat,
  input  logic [LANES-1:0]        sense_dat,
  output logic                    busy,
  output logic                    done,
  output logic                    sum,
  output logic                    carry
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NSTEP - 1);

  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q, step_nxt;
  logic [ROW_W-1:0]  brow_q, brow_eff;
  logic [COL_W-1:0]  bcol_q, bcol_eff;
  logic              go, issue;

  iss_t  [LANES-1:0] iss;
  slot_e [LANES-1:0] cap;
  logic  [NSLOT-1:0] fwd;

  assign go       = start & ~busy_q;
  assign issue    = go | (busy_q & (step_q != LAST));
  assign step_nxt = go ? '0 : step_q + 1'b1;
  assign brow_eff = go ? base_row : brow_q;
  assign bcol_eff = go ? base_col : bcol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      brow_q <= '0;
      bcol_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
        step_q <= '0;
        brow_q <= base_row;
        bcol_q <= base_col;
      end else if (busy_q) begin
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_nxt;
        end
      end
    end
  end

  mfa_prog u_prog (
    .iss_step (step_nxt),
    .cap_step (step_q),
    .iss      (iss),
    .cap      (cap)
  );

  mfa_scratch u_scr (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (busy_q),
    .cap      (cap),
    .sense    (sense_dat),
    .slot_nxt (fwd),
    .sum_q    (sum),
    .carry_q  (carry)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      iss_t lane_uop;
      assign lane_uop = issue ? iss[g] : ISS_IDLE;
      mfa_lane #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .GRP_OFS (SA_SHARE)
      ) u_lane (
        .clk      (clk),
        .rst      (rst),
        .uop      (lane_uop),
        .base_row (brow_eff),
        .base_col (bcol_eff),
        .fwd      (fwd),
        .vld      (cmd_vld[g]),
        .op       (cmd_op[g*OP_W +: OP_W]),
        .row      (cmd_row[g*ROW_W +: ROW_W]),
        .col      (cmd_col[g*COL_W +: COL_W]),
        .wdat     (cmd_wdat[g])
      );
    end
  endgenerate

  assign busy = busy_q;
  assign done = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cmd_vld == '0)); // R2
  AST_PAIR_SLOTS: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld == '1) |-> (step_q == 3'd2 || step_q == LAST)); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (busy_q && step_q == LAST) |=> (done_q && !busy_q)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start) |=> ($stable(sum) && $stable(carry))); // R8
  AST_BASE_KEEP: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(brow_q) && $stable(bcol_q))); // R9

endmodule

// File: tb/sim_mfa_seq.sv
`timescale 1ns/1ps
module sim_mfa_seq;
  localparam int RW = 4, CW = 5, SA = 8;
  localparam int NR = 1 << RW, NC = 1 << CW;
  localparam int AW = 1 + 3 + RW + CW + 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start;
  logic [RW-1:0] base_row;
  logic [CW-1:0] base_col;
  logic [1:0] cmd_vld, cmd_wdat, sense_dat;
  logic [5:0] cmd_op;
  logic [2*RW-1:0] cmd_row;
  logic [2*CW-1:0] cmd_col;
  logic busy, done, sum, carry;

  mfa_seq #(.ROW_W(RW), .COL_W(CW), .SA_SHARE(SA)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_row(base_row), .base_col(base_col),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_wdat(cmd_wdat), .sense_dat(sense_dat), .busy(busy), .done(done),
    .sum(sum), .carry(carry));

  logic mem [NR][NC];
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic maj3(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      logic [RW-1:0] r0, r1, r2;
      logic [CW-1:0] c;
      r0 = cmd_row[l*RW +: RW];
      r1 = r0 + 1'b1;
      r2 = r0 + 2'd2;
      c  = cmd_col[l*CW +: CW];
      case (cmd_op[l*3 +: 3])
        3'd1:    sense_dat[l] = ~mem[r0][c];
        3'd2:    sense_dat[l] = maj3(mem[r0][c], mem[r1][c], mem[r2][c]);
        3'd3:    sense_dat[l] = ~maj3(mem[r0][c], mem[r1][c], mem[r2][c]);
        default: sense_dat[l] = 1'b0;
      endcase
    end
  end

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++)
      if (cmd_vld[l] && cmd_op[l*3 +: 3] == 3'd4)
        mem[cmd_row[l*RW +: RW]][cmd_col[l*CW +: CW]] <= cmd_wdat[l];
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected command per cycle and lane from R3/R4/R6: {vld, op, row, col, wdat}
  function automatic logic [AW-1:0] exp_cmd(int cyc, int lane, int brow, int bcol,
                                            logic a, logic b, logic c);
    int op = 0, ro = 0, g = 0, v = 0;
    logic wd = 1'b0;
    case (cyc)
      1: if (lane == 0) begin v = 1; op = 1; ro = 2; g = 0; end
      2: if (lane == 1) begin v = 1; op = 4; ro = 2; g = 1; wd = ~c; end
      3: begin v = 1; op = (lane == 0) ? 3 : 2; ro = 0; g = lane; end
      4: if (lane == 1) begin v = 1; op = 4; ro = 4; g = 1; wd = ~maj3(a, b, c); end
      5: if (lane == 1) begin v = 1; op = 4; ro = 5; g = 1; wd = maj3(a, b, ~c); end
      6: begin v = 1; op = 2; ro = (lane == 0) ? 0 : 3; g = lane; end
      default: ;
    endcase
    if (v == 0) return '0;
    return {1'b1, 3'(op), RW'((brow + ro) % NR), CW'((bcol + g * SA) % NC), wd};
  endfunction

  task automatic run_add(logic a, logic b, logic c, int brow, int bcol, bit inject);
    int nrd = 0, nwr = 0, npair = 0;
    logic s0, c0;
    logic [AW-1:0] act, exp;
    int c1 = (bcol + SA) % NC;
    for (int k = 0; k < 6; k++) begin
      mem[(brow + k) % NR][bcol] <= 1'($urandom);
      mem[(brow + k) % NR][c1]   <= 1'($urandom);
    end
    @(negedge clk);
    mem[brow % NR][bcol] <= a; mem[(brow + 1) % NR][bcol] <= b; mem[(brow + 2) % NR][bcol] <= c;
    mem[brow % NR][c1] <= a;   mem[(brow + 1) % NR][c1] <= b;   mem[(brow + 3) % NR][c1] <= c;
    start = 1'b1; base_row = RW'(brow); base_col = CW'(bcol);
    @(negedge clk);
    start = 1'b0; base_row = RW'($urandom); base_col = CW'($urandom);
    for (int cyc = 1; cyc <= 6; cyc++) begin
      if (cyc > 1) @(negedge clk);
      chk(busy == 1'b1, "R2", $sformatf("busy cycle %0d", cyc), busy, 1);
      for (int l = 0; l < 2; l++) begin
        act = {cmd_vld[l], cmd_op[l*3 +: 3], cmd_row[l*RW +: RW], cmd_col[l*CW +: CW], cmd_wdat[l]};
        exp = exp_cmd(cyc, l, brow, bcol, a, b, c);
        chk(act == exp, "R3/R4/R6", $sformatf("cmd cycle %0d lane %0d", cyc, l), int'(act), int'(exp));
        if (cmd_vld[l] && cmd_op[l*3 +: 3] == 3'd4) nwr++;
        else if (cmd_vld[l]) nrd++;
      end
      if (cmd_vld == 2'b11) npair++;
      if (inject && cyc == 3) begin start = 1'b1; base_row = RW'(brow + 5); base_col = CW'(bcol + 3); end
      if (inject && cyc == 4) start = 1'b0;
    end
    @(negedge clk);
    chk(nrd == 5, "R5", "sense count", nrd, 5);
    chk(nwr == 3, "R5", "write count", nwr, 3);
    chk(npair == 2, "R5", "paired cycles", npair, 2);
    chk(done == 1'b1 && busy == 1'b0 && cmd_vld == 2'b00, "R2 R8", "done after six cycles",
        {done, busy, cmd_vld}, 4'b1000);
    chk(carry == maj3(a, b, c), "R7", $sformatf("carry a=%0d b=%0d c=%0d", a, b, c), carry, maj3(a, b, c));
    chk(sum == (a ^ b ^ c), "R7", $sformatf("sum a=%0d b=%0d c=%0d", a, b, c), sum, a ^ b ^ c);
    s0 = sum; c0 = carry;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R8", "done is one pulse", done, 0);
      chk(cmd_vld == 2'b00 && busy == 1'b0, inject ? "R9" : "R2", "no further commands",
          {busy, cmd_vld}, 0);
      chk(sum == s0 && carry == c0, "R8", "result held", {sum, carry}, {s0, c0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; base_row = '0; base_col = '0;
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) mem[r][c] <= 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, sum, carry, cmd_vld} == 0, "R1", "outputs in reset", {busy, done, sum, carry, cmd_vld}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, sum, carry, cmd_vld} == 0, "R1", "outputs after reset", {busy, done, sum, carry, cmd_vld}, 0);
    // directed: every operand combination
    for (int v = 0; v < 8; v++) run_add(v[2], v[1], v[0], 0, 0, v == 5);
    // directed: row and column wraparound
    run_add(1'b1, 1'b0, 1'b1, NR - 2, NC - 4, 1'b0);
    run_add(1'b0, 1'b1, 1'b1, NR - 1, NC - 8, 1'b1);
    // random operands and bases
    for (int i = 0; i < 24; i++)
      run_add(1'($urandom), 1'($urandom), 1'($urandom), $urandom % NR, $urandom % NC, ($urandom % 4) == 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule